// File: doc/BRIEF.md
# Strap-Addressed Control Byte Port on a Two-Wire Serial Bus

This block is a target on a two-wire serial bus of the I2C kind, running at up to 400 kHz. A host processor uses it to write one 8-bit control byte and to read an 8-bit status byte. The target address is a fixed base plus the value on three strap pins, so eight copies of the block can sit on one bus. The block oversamples SCL and SDA with a fast system clock. Both lines pass through a synchroniser and a glitch filter. The block then finds START and STOP conditions, matches the address, ACKs, and shifts data on SDA using an open-drain pull-down.

The control byte feeds the card-interface logic in the rest of the chip. Bit 0 is the run bit: 1 requests activation with a cold reset, and 0 requests deactivation. Each edge of bit 0 also produces a one-cycle request pulse. Bit 1 is the warm-reset request, and hardware clears it when the card answers or is declared mute. The other bits are plain levels:
- bit 2 selects the supply (1 = 3 V, 0 = 5 V);
- bit 3 stops the card clock;
- bit 4 sets the level at which the clock stops (1 = high);
- bits 6:5 select the card clock rate;
- bit 7 enables the card data path.

All pins are plain levels or pulses, with no valid/ready handshake. A written byte takes effect in the system-clock cycle after its eighth bit is taken. Status is sampled at the SCL falling edge that starts each read byte. The host cannot be held off, and SCL is never stretched.

Top module: `ctl_i2c_slave`

## Requirements
- R1: While reset is asserted and right after it is released, the control byte is 0x00, SDA is not pulled low, and neither request pulse is high.
- R2: The block answers only an address byte whose bits 7:1 equal 0x20 + {sel2,sel1,sel0}, which makes the byte 0x40 + 2×sel. Bit 0 of the address byte is the direction (1 = read). Any other address gets no ACK, and the control byte keeps its value through the whole transfer.
- R3: On a write, each data byte (MSB first) is ACKed during the ninth SCL pulse and then replaces the control byte. When several bytes are written, the last one sets the control byte.
- R4: SDA drive changes only in the cycles that follow a filtered SCL falling edge, a START or a STOP, and SDA is released whenever the block is idle.
- R5: On a read, the block sends the status input MSB first. It samples the status again for each byte the host ACKs. After a NACK it releases SDA.
- R6: A high level on card_answer or card_mute clears control bit 1 in the next cycle, and this clear wins over a write in the same cycle.
- R7: A 0→1 change of control bit 0 gives one cycle of start_req, and a 1→0 change gives one cycle of stop_req. The two pulses are never high together.
- R8: A repeated START in the middle of a byte drops the partial byte and returns the block to address reception.
- R9: A pulse on SCL that lasts fewer system-clock cycles than the filter length is ignored and does not shift a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20× the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL pad level |
| sda_i | input | 1 | SDA pad level |
| sda_pull_o | output | 1 | 1 = pull SDA low |
| addr_sel_i | input | 3 | Address strap value added to the base |
| status_i | input | 8 | Status byte returned on reads |
| card_answer_i | input | 1 | Card started answering; clears warm reset |
| card_mute_i | input | 1 | Card declared mute; clears warm reset |
| ctrl_o | output | 8 | Control byte |
| start_req_o | output | 1 | One-cycle pulse on control bit 0 rising |
| stop_req_o | output | 1 | One-cycle pulse on control bit 0 falling |

## Verification
Some rules are checked every cycle: SDA drive changes only after an SCL fall or a bus condition, SDA is released when idle, the warm-reset bit is cleared by a card event, the control byte changes only on a write or a clear, and the request pulses are exclusive and agree with bit 0. Other behaviour is only shown by the bench's bus transactions. This covers which strap/address pairs get an ACK, the exact bytes stored and sent back, the reload of status on ACK, the loss of a partial byte at a repeated START, and the rejection of SCL glitches.

// File: rtl/ctl_i2c_pkg.sv
package ctl_i2c_pkg;
  localparam int BYTE_W  = 8;
  localparam int CNT_W   = 4;
  localparam int CB_RUN  = 0;
  localparam int CB_WARM = 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } fsm_e;
endpackage

// File: rtl/ctl_line_filter.sv
module ctl_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;
  logic                   level_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      hist_q  <= '1;
      level_o <= 1'b1;
      level_d <= 1'b1;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], line_i};
      hist_q  <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      level_d <= level_o;
      if (&hist_q)
        level_o <= 1'b1;
      else if (~|hist_q)
        level_o <= 1'b0;
    end
  end

  assign rise_o = level_o & ~level_d;
  assign fall_o = ~level_o & level_d;
endmodule

// File: rtl/ctl_cond_detect.sv
module ctl_cond_detect (
  input  logic scl_lvl,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic start_o,
  output logic stop_o
);
  assign start_o = scl_lvl & sda_fall;
  assign stop_o  = scl_lvl & sda_rise;
endmodule

// File: rtl/ctl_i2c_fsm.sv
module ctl_i2c_fsm
  import ctl_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        my_addr,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic [BYTE_W-1:0] status_i,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_pull,
  output logic              idle_o
);
  fsm_e              state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic              rw_q;
  logic              nack_q;
  logic              ack_drv;
  logic              rd_drv;
  logic              byte_done;

  assign byte_done = (bit_cnt == CNT_W'(BYTE_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      rw_q     <= 1'b0;
      nack_q   <= 1'b0;
      ack_drv  <= 1'b0;
      rd_drv   <= 1'b0;
      wr_valid <= 1'b0;
      wr_data  <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (bus_start) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        ack_drv <= 1'b0;
        rd_drv  <= 1'b0;
      end else if (bus_stop) begin
        state   <= ST_IDLE;
        ack_drv <= 1'b0;
        rd_drv  <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ADDR: begin
            if (scl_rise) begin
              rx_sh   <= {rx_sh[BYTE_W-2:0], sda_lvl};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && byte_done) begin
              if (rx_sh[BYTE_W-1:1] == my_addr) begin
                rw_q    <= rx_sh[0];
                ack_drv <= 1'b1;
                state   <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              ack_drv <= 1'b0;
              bit_cnt <= '0;
              if (rw_q) begin
                tx_sh  <= status_i;
                rd_drv <= 1'b1;
                state  <= ST_RD;
              end else begin
                state <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              rx_sh   <= {rx_sh[BYTE_W-2:0], sda_lvl};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && byte_done) begin
              wr_valid <= 1'b1;
              wr_data  <= rx_sh;
              ack_drv  <= 1'b1;
              state    <= ST_WR_ACK;
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              ack_drv <= 1'b0;
              bit_cnt <= '0;
              state   <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall) begin
              if (byte_done) begin
                rd_drv <= 1'b0;
                state  <= ST_RD_ACK;
              end else begin
                tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              nack_q <= sda_lvl;
            end else if (scl_fall) begin
              if (nack_q) begin
                state <= ST_IDLE;
              end else begin
                tx_sh   <= status_i;
                rd_drv  <= 1'b1;
                bit_cnt <= '0;
                state   <= ST_RD;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_pull = ack_drv | (rd_drv & ~tx_sh[BYTE_W-1]);
  assign idle_o   = (state == ST_IDLE);
endmodule

// File: rtl/ctl_byte_reg.sv
module ctl_byte_reg
  import ctl_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              hw_clear,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic              start_req_o,
  output logic              stop_req_o
);
  logic run_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o <= '0;
      run_d  <= 1'b0;
    end else begin
      run_d <= ctrl_o[CB_RUN];
      if (wr_valid)
        ctrl_o <= wr_data;
      if (hw_clear)
        ctrl_o[CB_WARM] <= 1'b0;
    end
  end

  assign start_req_o = ctrl_o[CB_RUN] & ~run_d;
  assign stop_req_o  = ~ctrl_o[CB_RUN] & run_d;
endmodule

// File: rtl/ctl_i2c_slave.sv
module ctl_i2c_slave
  import ctl_i2c_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3,
  parameter logic [6:0] ADDR_BASE   = 7'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic [2:0]        addr_sel_i,
  input  logic [BYTE_W-1:0] status_i,
  input  logic              card_answer_i,
  input  logic              card_mute_i,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic              start_req_o,
  output logic              stop_req_o
);
  localparam int N_LINES = 2;
  localparam int L_SDA   = 0;
  localparam int L_SCL   = 1;

  logic [N_LINES-1:0] pad_lines;
  logic [N_LINES-1:0] line_lvl;
  logic [N_LINES-1:0] line_rise;
  logic [N_LINES-1:0] line_fall;
  logic               scl_rise;
  logic               scl_fall;
  logic               bus_start;
  logic               bus_stop;
  logic               wr_valid;
  logic [BYTE_W-1:0]  wr_data;
  logic               fsm_idle;
  logic               hw_clear;
  logic [6:0]         my_addr;

  assign pad_lines = {scl_i, sda_i};
  assign my_addr   = ADDR_BASE + {4'b0000, addr_sel_i};
  assign hw_clear  = card_answer_i | card_mute_i;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    ctl_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (pad_lines[g]),
      .level_o(line_lvl[g]),
      .rise_o (line_rise[g]),
      .fall_o (line_fall[g])
    );
  end

  assign scl_rise = line_rise[L_SCL];
  assign scl_fall = line_fall[L_SCL];

  ctl_cond_detect u_cond (
    .scl_lvl (line_lvl[L_SCL]),
    .sda_rise(line_rise[L_SDA]),
    .sda_fall(line_fall[L_SDA]),
    .start_o (bus_start),
    .stop_o  (bus_stop)
  );

  ctl_i2c_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .my_addr  (my_addr),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_lvl  (line_lvl[L_SDA]),
    .bus_start(bus_start),
    .bus_stop (bus_stop),
    .status_i (status_i),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .sda_pull (sda_pull_o),
    .idle_o   (fsm_idle)
  );

  ctl_byte_reg u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_data    (wr_data),
    .hw_clear   (hw_clear),
    .ctrl_o     (ctrl_o),
    .start_req_o(start_req_o),
    .stop_req_o (stop_req_o)
  );
endmodule

// File: rtl/ctl_i2c_slave_chk.sv
module ctl_i2c_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_pull_o,
  input logic [7:0] ctrl_o,
  input logic       start_req_o,
  input logic       stop_req_o,
  input logic       card_answer_i,
  input logic       card_mute_i,
  input logic       wr_valid,
  input logic       scl_fall,
  input logic       bus_start,
  input logic       bus_stop,
  input logic       fsm_idle
);
  // R4: drive changes only after SCL fall or a bus condition
  p_drive_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> $past(scl_fall || bus_start || bus_stop));

  // R4: idle means released
  p_idle_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fsm_idle |-> !sda_pull_o);

  // R6: card event clears warm bit
  p_warm_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (card_answer_i || card_mute_i) |=> !ctrl_o[1]);

  // R3: control byte moves only on a write or a hardware clear
  p_ctrl_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_o) |-> $past(wr_valid || card_answer_i || card_mute_i));

  // R7: pulses exclusive and consistent with bit 0
  p_req_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_req_o && stop_req_o));

  p_start_lvl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_req_o |-> ctrl_o[0]);

  p_stop_lvl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req_o |-> !ctrl_o[0]);

  // R1: nothing driven while in reset
  always_comb begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!start_req_o && !stop_req_o && ctrl_o == 8'h00);
    end
  end
endmodule

bind ctl_i2c_slave ctl_i2c_slave_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sda_pull_o   (sda_pull_o),
  .ctrl_o       (ctrl_o),
  .start_req_o  (start_req_o),
  .stop_req_o   (stop_req_o),
  .card_answer_i(card_answer_i),
  .card_mute_i  (card_mute_i),
  .wr_valid     (wr_valid),
  .scl_fall     (scl_fall),
  .bus_start    (bus_start),
  .bus_stop     (bus_stop),
  .fsm_idle     (fsm_idle)
);

// File: tb/test_ctl_i2c_slave.sv
module test_ctl_i2c_slave;
  localparam int Q = 12;
  localparam int NV = 6;
  // {sel[2:0], addr[7:0], data[7:0], ack_exp, ctrl_exp[7:0]}
  localparam logic [27:0] VEC [NV] = '{
    {3'd0, 8'h40, 8'hA5, 1'b1, 8'hA5},
    {3'd5, 8'h4A, 8'h3C, 1'b1, 8'h3C},
    {3'd5, 8'h48, 8'hFF, 1'b0, 8'h3C},
    {3'd7, 8'h4E, 8'h00, 1'b1, 8'h00},
    {3'd2, 8'h44, 8'h81, 1'b1, 8'h81},
    {3'd2, 8'h46, 8'h7E, 1'b0, 8'h81}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_pull;
  logic [2:0] addr_sel = 3'd0;
  logic [7:0] status = 8'h00;
  logic       card_answer = 1'b0;
  logic       card_mute = 1'b0;
  logic [7:0] ctrl;
  logic       start_req, stop_req;
  logic       sda_bus;
  logic       glitch_en = 1'b0;
  int         n_chk = 0, n_bad = 0;
  int         n_start = 0, n_stop = 0, r4_bad = 0;
  logic       pull_prev = 1'b0;

  always #2 clk = ~clk;
  assign sda_bus = sda_m & ~sda_pull;

  ctl_i2c_slave i_ctl_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .addr_sel_i(addr_sel), .status_i(status),
    .card_answer_i(card_answer), .card_mute_i(card_mute),
    .ctrl_o(ctrl), .start_req_o(start_req), .stop_req_o(stop_req)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (start_req) n_start++;
      if (stop_req) n_stop++;
      if (sda_pull !== pull_prev && scl_m) r4_bad++;
    end
    pull_prev = sda_pull;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic s);
    sda_m = b;
    if (glitch_en) begin
      wait_cyc(2); scl_m = 1'b1; wait_cyc(1); scl_m = 1'b0; wait_cyc(Q - 3);
    end else wait_cyc(Q);
    scl_m = 1'b1; wait_cyc(Q);
    s = sda_bus; wait_cyc(Q);
    scl_m = 1'b0; wait_cyc(Q);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wait_cyc(Q); scl_m = 1'b1; wait_cyc(Q);
    sda_m = 1'b0; wait_cyc(Q); scl_m = 1'b0; wait_cyc(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wait_cyc(Q); scl_m = 1'b1; wait_cyc(Q);
    sda_m = 1'b1; wait_cyc(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_x(v[i], s);
    bit_x(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_x(1'b1, s);
      v[i] = s;
    end
  endtask

  task automatic write_one(input logic [7:0] a, input logic [7:0] d,
                           output logic ack_a, output logic ack_d);
    bus_start;
    send_byte(a, ack_a);
    send_byte(d, ack_d);
    bus_stop;
    wait_cyc(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic aa, ad, s;
    logic [7:0] rb;
    int st0, sp0;
    wait_cyc(5);
    chk("R1 ctrl in reset", ctrl, 8'h00);
    chk("R1 pull in reset", sda_pull, 1'b0);
    rst_n = 1'b1;
    wait_cyc(3);
    chk("R1 ctrl after reset", ctrl, 8'h00);
    chk("R1 pulses after reset", {start_req, stop_req}, 2'b00);

    // R2/R3 table
    for (int k = 0; k < NV; k++) begin
      addr_sel = VEC[k][27:25];
      write_one(VEC[k][24:17], VEC[k][16:9], aa, ad);
      chk("R2 address ack", aa, VEC[k][8]);
      chk("R3 data ack", ad, VEC[k][8]);
      chk("R3 ctrl value", ctrl, VEC[k][7:0]);
    end
    chk("R7 start pulses", n_start, 2);
    chk("R7 stop pulses", n_stop, 1);

    // R3 multi-byte: last wins
    addr_sel = 3'd2;
    bus_start;
    send_byte(8'h44, aa);
    send_byte(8'h11, ad);
    send_byte(8'h00, ad);
    chk("R3 second byte ack", ad, 1'b1);
    bus_stop; wait_cyc(4);
    chk("R3 last byte wins", ctrl, 8'h00);
    chk("R7 stop on bit0 fall", n_stop, 2);

    // R6 warm clear by answer and mute
    write_one(8'h44, 8'h06, aa, ad);
    card_answer = 1'b1; wait_cyc(1); card_answer = 1'b0; wait_cyc(1);
    chk("R6 cleared by answer", ctrl, 8'h04);
    write_one(8'h44, 8'h0E, aa, ad);
    card_mute = 1'b1; wait_cyc(1); card_mute = 1'b0; wait_cyc(1);
    chk("R6 cleared by mute", ctrl, 8'h0C);

    // R5 read two bytes
    status = 8'hC6;
    bus_start;
    send_byte(8'h45, aa);
    chk("R5 read address ack", aa, 1'b1);
    recv_byte(rb);
    chk("R5 first status byte", rb, 8'hC6);
    status = 8'h3A;
    bit_x(1'b0, s);
    recv_byte(rb);
    chk("R5 reloaded status byte", rb, 8'h3A);
    bit_x(1'b1, s);
    wait_cyc(2);
    chk("R5 released after NACK", sda_pull, 1'b0);
    bus_stop; wait_cyc(4);
    chk("R5 read leaves ctrl", ctrl, 8'h0C);

    // R8 repeated start mid byte
    st0 = n_start; sp0 = n_stop;
    bus_start;
    send_byte(8'h44, aa);
    for (int i = 0; i < 4; i++) bit_x(1'b1, s);
    bus_start;
    send_byte(8'h44, aa);
    chk("R8 address after restart", aa, 1'b1);
    send_byte(8'h5B, ad);
    bus_stop; wait_cyc(4);
    chk("R8 ctrl after restart", ctrl, 8'h5B);
    chk("R7 one start pulse", n_start - st0, 1);
    chk("R7 no stop pulse", n_stop - sp0, 0);

    // R9 SCL glitches
    glitch_en = 1'b1;
    write_one(8'h44, 8'h72, aa, ad);
    glitch_en = 1'b0;
    chk("R9 ack with glitches", {aa, ad}, 2'b11);
    chk("R9 data with glitches", ctrl, 8'h72);

    chk("R4 no drive change while SCL high", r4_bad, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule